// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block models a single-port synchronous static RAM. Its timing removes any dead cycle when the bus changes direction. Address and command are captured on every enabled rising edge. A read returns its word during the following cycle. A write takes its data one enabled edge after its address, which is the same slot in which a read would have returned data. This is why reads and writes can alternate on consecutive edges with no idle cycle in between.

An active-low clock enable stalls the whole pipeline. While it is high, no command is captured. A write that still waits for its data is postponed to the next enabled edge, and the last read word stays on the output. The data buses are split into an input and an output bus. The high-impedance state of a real pad is shown by a drive-enable flag that follows the active-low output enable. The array holds 2^`ADDR_W` words of `DATA_W` bits. `ADDR_W` = 17 with `DATA_W` = 8 gives the full 128K x 8 organisation. The default is kept small so that elaboration stays light.

Top module: `zbt_sram`

## Requirements
- R1: A read command (`cs_n`=0, `cen_n`=0, `we_n`=1) at an edge makes the word at the captured address appear on `rdata` during the next cycle, while `oe_n` is 0.
- R2: A write command (`cs_n`=0, `cen_n`=0, `we_n`=0) at an edge stores `wdata` as sampled at the next enabled edge into the captured address.
- R3: An edge with `cen_n`=1 is ignored. No address or command is captured, and a pending write keeps waiting for its data until the next enabled edge.
- R4: While `cen_n` stays 1, `rdata_oe` and the read word stay unchanged apart from the effect of `oe_n`.
- R5: Read and write commands on consecutive enabled edges, in any mix, all complete correctly with no idle cycle between them.
- R6: `rdata_oe` is 1 only when `oe_n` is 0 and the last enabled edge carried a read. When `rdata_oe` is 0, `rdata` is all zeros.
- R7: An enabled edge with `cs_n`=1 writes nothing and leaves the output undriven in the next cycle. A write already pending still completes at that edge.
- R8: A read of the address written by the immediately preceding write command returns that write's data, which is taken from `wdata` at the same edge.
- R9: A synchronous reset (`rst_n`=0 at an edge) drops any pending write and clears the output drive. Memory contents are kept.
- R10: In the cycle after a write command, the output is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address |
| we_n | input | 1 | Write command when low, read when high |
| cs_n | input | 1 | Chip select, active low |
| cen_n | input | 1 | Clock enable, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| wdata | input | DATA_W | Write data, sampled one enabled edge after its address |
| rdata | output | DATA_W | Read data, zero when not driven |
| rdata_oe | output | 1 | High when rdata is driven |

## Verification
A behavioural model in the bench, built on an associative array and a pending-write flag, is compared with the ports every cycle. The stimulus starts with the read and write sequences that have gaps of stalled edges: there a wrong capture or a dropped postponed write shows up as the wrong word or a missing hold. Strict read/write alternation on one address and on different addresses separates correct forwarding from a read of stale memory. Deselects, output-enable toggling and a reset in the middle of a pending write then each isolate one control path. A long random mix over a small address range finally exercises all of them together.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we_n,
  input  logic              cs_n,
  input  logic              cen_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic              pend_vld;
  logic [ADDR_W-1:0] pend_addr;
  logic              out_vld;
  logic [DATA_W-1:0] rd_q;

  wire adv    = !cen_n;
  wire rd_cmd = adv && !cs_n && we_n;
  wire wr_cmd = adv && !cs_n && !we_n;
  wire fwd    = pend_vld && (pend_addr == addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      out_vld  <= 1'b0;
    end else if (adv) begin
      pend_vld <= wr_cmd;
      out_vld  <= rd_cmd;
    end
  end

  always_ff @(posedge clk)
    if (adv) pend_addr <= addr;

  always_ff @(posedge clk)
    if (rst_n && adv && pend_vld) mem[pend_addr] <= wdata;

  always_ff @(posedge clk)
    if (rst_n && rd_cmd) rd_q <= fwd ? wdata : mem[addr];

  assign rdata_oe = out_vld && !oe_n;
  assign rdata    = rdata_oe ? rd_q : '0;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we_n,
  input logic              cs_n,
  input logic              cen_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_oe,
  input logic              pend_vld,
  input logic              out_vld,
  input logic [DATA_W-1:0] rd_q
);
  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> !oe_n); // R6
  AST_ZERO_WHEN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == '0); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> $stable(out_vld) && $stable(rd_q) && $stable(pend_vld)); // R4
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && cs_n) |=> !rdata_oe && !pend_vld); // R7
  AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !cs_n && !we_n) |=> pend_vld && !rdata_oe); // R10
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !cs_n && we_n) |=> out_vld); // R1
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> !pend_vld && !out_vld); // R9
endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/zbt_sram_bench.sv
module zbt_sram_bench;
  localparam int AW = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we_n = 1'b1, cs_n = 1'b1, cen_n = 1'b0, oe_n = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit chk_en = 1'b0;
  string cur_req = "R9";

  always #10 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .DATA_W(DW)) u_zbt_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we_n(we_n), .cs_n(cs_n),
    .cen_n(cen_n), .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  logic [DW-1:0] mm [int];
  bit            m_pend = 1'b0;
  int            m_paddr = 0;
  bit            m_out = 1'b0;
  bit            m_known = 1'b0;
  logic [DW-1:0] m_rd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 1'b0;
      m_out  = 1'b0;
    end else if (!cen_n) begin
      if (m_pend) mm[m_paddr] = wdata;
      if (!cs_n && we_n) begin
        m_out   = 1'b1;
        m_known = mm.exists(int'(addr));
        if (m_known) m_rd = mm[int'(addr)];
      end else begin
        m_out = 1'b0;
      end
      m_pend  = !cs_n && !we_n;
      m_paddr = int'(addr);
    end
  end

  task automatic compare();
    bit exp_oe;
    exp_oe = m_out && !oe_n;
    checks++;
    if (rdata_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s: rdata_oe=%0b expected %0b at %0t", cur_req, rdata_oe, exp_oe, $time);
    end else if (exp_oe && m_known && rdata !== m_rd) begin
      errors++;
      $display("FAIL %s: rdata=%02h expected %02h at %0t", cur_req, rdata, m_rd, $time);
    end else if (!exp_oe && rdata !== '0) begin
      errors++;
      $display("FAIL %s: rdata=%02h expected 00 when undriven at %0t", cur_req, rdata, $time);
    end
  endtask

  task automatic cyc(input int a, input bit w, input bit cs, input bit ce,
                     input bit oe, input int d);
    @(negedge clk);
    if (chk_en) compare();
    addr = AW'(a); we_n = w; cs_n = cs; cen_n = ce; oe_n = oe; wdata = DW'(d);
  endtask

  task automatic rd(input int a);          cyc(a, 1, 0, 0, 0, 0); endtask
  task automatic wr(input int a, input int d); cyc(a, 0, 0, 0, 0, d); endtask
  task automatic stall(input int d);       cyc(0, 1, 1, 1, 0, d); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cs_n  = 1'b1;
    @(negedge clk);
    checks++;
    if (rdata_oe !== 1'b0) begin
      errors++;
      $display("FAIL R9: rdata_oe=%0b expected 0 after reset", rdata_oe);
    end
    chk_en = 1'b1;

    cur_req = "R2";
    for (int i = 0; i < 16; i++) begin
      wr(i, 0);
      cyc(0, 1, 1, 0, 0, 8'h10 + i);
    end
    cur_req = "R1";
    for (int i = 0; i < 16; i++) rd(i);
    cyc(0, 1, 1, 0, 0, 0);

    cur_req = "R3";
    rd(2); stall(0); rd(5); stall(0); stall(0); rd(6); rd(7);
    wr(3, 0); stall(8'hA3); wr(4, 8'hA3); stall(8'hA4); stall(8'hB0);
    wr(8, 8'hA4); cyc(0, 1, 1, 0, 0, 8'hA8);
    cur_req = "R4";
    rd(3); stall(0); cyc(0, 1, 1, 1, 1, 0); stall(0); rd(4); rd(8);
    cyc(0, 1, 1, 0, 0, 0);

    cur_req = "R5";
    for (int i = 0; i < 10; i++) begin
      wr(9, (i == 0) ? 0 : 8'h50 + i - 1);
      rd(10);
    end
    cur_req = "R8";
    wr(11, 8'h59);
    rd(11);
    wr(11, 0);
    rd(11);
    cyc(0, 1, 1, 0, 0, 8'hC1);
    rd(11);

    cur_req = "R7";
    wr(12, 0);
    cyc(12, 1, 1, 0, 0, 8'h77);
    cyc(12, 0, 1, 0, 0, 8'h88);
    rd(12);
    cur_req = "R10";
    wr(13, 0);
    rd(13);
    cyc(0, 1, 1, 0, 0, 0);
    cur_req = "R6";
    rd(12); cyc(0, 1, 1, 0, 1, 0); cyc(0, 1, 1, 1, 0, 0); cyc(0, 1, 1, 1, 1, 0);

    cur_req = "R9";
    wr(14, 0);
    @(negedge clk);
    compare();
    rst_n = 1'b0; cs_n = 1'b1; wdata = 8'hEE;
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    rd(14); rd(1); cyc(0, 1, 1, 0, 0, 0);

    cur_req = "R5";
    for (int i = 0; i < 3000; i++)
      cyc($urandom_range(0, 15), $urandom_range(0, 1), ($urandom_range(0, 4) == 0),
          ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0), $urandom_range(0, 255));
    cyc(0, 1, 1, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule